// File: doc/BRIEF.md
# Machine-Mode CSR and Synchronous Trap Unit

This block holds the control and status registers of a small multi-cycle 32-bit RISC-V integer core that runs in machine mode only. The core's sequencer sends one CSR instruction at a time. In a single clock edge the unit reads the old value of the addressed register and writes the updated value back. The old value returns to the sequencer one cycle later, so that it can be written to the destination register. Three update kinds exist: full write, set-bits and clear-bits. Each kind has a register-operand form and a 5-bit-immediate form.

The unit also runs a 64-bit cycle counter and a 64-bit retired-instruction counter. Both are read-only and are seen as two 32-bit halves. The unit records synchronous traps: environment calls, misaligned jump targets, misaligned load and store addresses, and illegal CSR accesses. For each trap it saves the faulting PC, the cause and the offending address. It then redirects the core to the trap vector. For the exception-return instruction it redirects the core to the saved PC. There is no interrupt logic.

Top module: `csr_trap_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, `resp_valid` and `redirect_valid` are 0. Reset clears both counters and the cause register (0x342), and loads the trap-vector register (0x305) with the parameter `RESET_VEC`.
- R2: A request with `req_op`=2'b00 (write) puts the operand into the addressed register and returns the register's previous value.
- R3: A request with `req_op`=2'b01 (set) ORs the operand into the register. A request with `req_op`=2'b10 (clear) clears the operand's bits in the register. Both return the previous value.
- R4: When `req_imm`=1 the operand is `req_rs1_idx` zero-extended to 32 bits, and `req_rs1_val` is ignored. When `req_imm`=0 the operand is `req_rs1_val`.
- R5: A set or clear whose operand is zero, or whose register form names x0 (`req_rs1_idx`=0), writes nothing. Such a request is legal even on a read-only counter and returns the current value.
- R6: The cycle counter advances by one on every clock edge out of reset. Address 0xC00 reads its low half and 0xC80 its high half.
- R7: The retired-instruction counter advances only on edges where `retire` is 1 and no trap is taken. Address 0xC02 reads its low half and 0xC82 its high half.
- R8: When a trap is taken, the faulting PC (`insn_pc`) goes into 0x341 and the cause code into 0x342. Register 0x343 receives `fault_addr` for a misaligned trap and 0 for any other trap. In the next cycle `redirect_valid`=1 and `redirect_pc` is the trap vector with bits 1:0 cleared. The scratch register at 0x340 takes no part in traps.
- R9: Trap priority, highest first: misaligned jump (cause 0), misaligned load (4), misaligned store (6), environment call (11), illegal CSR (2). A CSR request in the same cycle as any trap input is dropped, with no write and no response.
- R10: Each of the following raises a trap with cause 2 and no response: a CSR address outside {0x305, 0x340, 0x341, 0x342, 0x343, 0xC00, 0xC80, 0xC02, 0xC82}, `req_op`=2'b11, or a write to a read-only counter that R5 does not excuse.
- R11: `mret` makes `redirect_valid`=1 in the next cycle, with `redirect_pc` equal to the saved PC. A trap in the same cycle takes precedence and redirects to the trap vector instead.
- R12: A legal CSR request gives `resp_valid`=1 exactly one cycle later. `resp_rdata` then holds the register value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | CSR instruction request this cycle |
| req_op | input | 2 | 00 write, 01 set bits, 10 clear bits, 11 reserved |
| req_imm | input | 1 | Immediate form: operand taken from `req_rs1_idx` |
| req_addr | input | 12 | CSR address |
| req_rs1_idx | input | 5 | Source register index or 5-bit immediate |
| req_rs1_val | input | 32 | Source register value |
| insn_pc | input | 32 | PC of the instruction now executing |
| retire | input | 1 | Instruction retires this cycle |
| exc_ecall | input | 1 | Environment call |
| exc_ld_misalign | input | 1 | Misaligned load address |
| exc_st_misalign | input | 1 | Misaligned store address |
| exc_jmp_misalign | input | 1 | Misaligned jump target |
| fault_addr | input | 32 | Offending address for misaligned traps |
| mret | input | 1 | Exception-return instruction |
| resp_valid | output | 1 | Old CSR value available |
| resp_rdata | output | 32 | Old CSR value |
| redirect_valid | output | 1 | PC redirect this cycle |
| redirect_pc | output | 32 | New PC |

## Verification
Several functions can fall in the same cycle: a retire strobe with a trap, a CSR request with a trap input, an exception return with a trap, and several trap inputs at once. The bench provokes each of these pairs directly, and also lets them meet by chance during a long random run. Expected results come from a bench model that follows the priority rules. The model checks that the counter does not advance when a trap coincides with a retire, that the dropped request writes nothing, and that the redirect target and cause code follow the winning event.

// File: rtl/csr_trap_pkg.sv
package csr_trap_pkg;

    localparam int XLEN  = 32;
    localparam int CNT_W = 64;
    localparam int AW    = 12;
    localparam int IMM_W = 5;

    typedef enum logic [1:0] {
        CSR_OP_WRITE = 2'b00,
        CSR_OP_SET   = 2'b01,
        CSR_OP_CLEAR = 2'b10,
        CSR_OP_RSVD  = 2'b11
    } csr_op_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_TVEC,
        SEL_SCRATCH,
        SEL_EPC,
        SEL_CAUSE,
        SEL_TVAL,
        SEL_CYC_LO,
        SEL_CYC_HI,
        SEL_RET_LO,
        SEL_RET_HI
    } csr_sel_e;

    typedef struct packed {
        logic     hit;
        logic     ro;
        csr_sel_e sel;
    } csr_dec_t;

    typedef struct packed {
        logic            take;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
    } trap_info_t;

    localparam logic [AW-1:0] ADDR_TVEC    = 12'h305;
    localparam logic [AW-1:0] ADDR_SCRATCH = 12'h340;
    localparam logic [AW-1:0] ADDR_EPC     = 12'h341;
    localparam logic [AW-1:0] ADDR_CAUSE   = 12'h342;
    localparam logic [AW-1:0] ADDR_TVAL    = 12'h343;
    localparam logic [AW-1:0] ADDR_CYC_LO  = 12'hC00;
    localparam logic [AW-1:0] ADDR_CYC_HI  = 12'hC80;
    localparam logic [AW-1:0] ADDR_RET_LO  = 12'hC02;
    localparam logic [AW-1:0] ADDR_RET_HI  = 12'hC82;

    localparam logic [XLEN-1:0] CAUSE_JMP_MIS = 32'd0;
    localparam logic [XLEN-1:0] CAUSE_ILLEGAL = 32'd2;
    localparam logic [XLEN-1:0] CAUSE_LD_MIS  = 32'd4;
    localparam logic [XLEN-1:0] CAUSE_ST_MIS  = 32'd6;
    localparam logic [XLEN-1:0] CAUSE_ECALL   = 32'd11;

    function automatic csr_dec_t csr_decode(input logic [AW-1:0] a);
        csr_dec_t d;
        d = '{hit: 1'b1, ro: 1'b0, sel: SEL_NONE};
        case (a)
            ADDR_TVEC:    d.sel = SEL_TVEC;
            ADDR_SCRATCH: d.sel = SEL_SCRATCH;
            ADDR_EPC:     d.sel = SEL_EPC;
            ADDR_CAUSE:   d.sel = SEL_CAUSE;
            ADDR_TVAL:    d.sel = SEL_TVAL;
            ADDR_CYC_LO:  begin d.sel = SEL_CYC_LO; d.ro = 1'b1; end
            ADDR_CYC_HI:  begin d.sel = SEL_CYC_HI; d.ro = 1'b1; end
            ADDR_RET_LO:  begin d.sel = SEL_RET_LO; d.ro = 1'b1; end
            ADDR_RET_HI:  begin d.sel = SEL_RET_HI; d.ro = 1'b1; end
            default:      d.hit = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic [XLEN-1:0] csr_modify(input csr_op_e op,
                                                   input logic [XLEN-1:0] old_v,
                                                   input logic [XLEN-1:0] opnd);
        case (op)
            CSR_OP_SET:   return old_v | opnd;
            CSR_OP_CLEAR: return old_v & ~opnd;
            default:      return opnd;
        endcase
    endfunction

endpackage

// File: rtl/csr_counter.sv
module csr_counter #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [WIDTH-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)      value <= '0;
        else if (inc) value <= value + 1'b1;
    end
endmodule

// File: rtl/csr_operand_alu.sv
module csr_operand_alu
    import csr_trap_pkg::*;
(
    input  logic [1:0]       op,
    input  logic             imm,
    input  logic [IMM_W-1:0] rs1_idx,
    input  logic [XLEN-1:0]  rs1_val,
    input  logic [XLEN-1:0]  old_val,
    output logic             skip_wr,
    output logic [XLEN-1:0]  new_val
);
    localparam int PAD = XLEN - IMM_W;

    csr_op_e         op_e;
    logic [XLEN-1:0] operand;

    always_comb begin
        op_e    = csr_op_e'(op);
        operand = imm ? {{PAD{1'b0}}, rs1_idx} : rs1_val;
        skip_wr = (op_e != CSR_OP_WRITE) &&
                  ((operand == '0) || (!imm && rs1_idx == '0));
        new_val = csr_modify(op_e, old_val, operand);
    end
endmodule

// File: rtl/csr_trap_ctrl.sv
module csr_trap_ctrl
    import csr_trap_pkg::*;
(
    input  logic            jmp_mis,
    input  logic            ld_mis,
    input  logic            st_mis,
    input  logic            ecall,
    input  logic            illegal,
    input  logic [XLEN-1:0] fault_addr,
    output trap_info_t      trap
);
    always_comb begin
        trap.take  = jmp_mis | ld_mis | st_mis | ecall | illegal;
        trap.tval  = '0;
        trap.cause = '0;
        if (jmp_mis) begin
            trap.cause = CAUSE_JMP_MIS;
            trap.tval  = fault_addr;
        end else if (ld_mis) begin
            trap.cause = CAUSE_LD_MIS;
            trap.tval  = fault_addr;
        end else if (st_mis) begin
            trap.cause = CAUSE_ST_MIS;
            trap.tval  = fault_addr;
        end else if (ecall) begin
            trap.cause = CAUSE_ECALL;
        end else if (illegal) begin
            trap.cause = CAUSE_ILLEGAL;
        end
    end
endmodule

// File: rtl/csr_trap_unit.sv
module csr_trap_unit
    import csr_trap_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_op,
    input  logic        req_imm,
    input  logic [11:0] req_addr,
    input  logic [4:0]  req_rs1_idx,
    input  logic [31:0] req_rs1_val,
    input  logic [31:0] insn_pc,
    input  logic        retire,
    input  logic        exc_ecall,
    input  logic        exc_ld_misalign,
    input  logic        exc_st_misalign,
    input  logic        exc_jmp_misalign,
    input  logic [31:0] fault_addr,
    input  logic        mret,
    output logic        resp_valid,
    output logic [31:0] resp_rdata,
    output logic        redirect_valid,
    output logic [31:0] redirect_pc
);
    localparam int HALF = CNT_W / 2;

    logic [XLEN-1:0]  mtvec_q, mepc_q, mcause_q, mtval_q, mscratch_q;
    logic [CNT_W-1:0] cyc_val, ret_val;
    logic [XLEN-1:0]  rd_old, new_val;
    logic             skip_wr, illegal, ext_exc, csr_we, ret_inc;
    csr_dec_t         dec;
    trap_info_t       trap;

    always_comb begin
        dec = csr_decode(req_addr);
        case (dec.sel)
            SEL_TVEC:    rd_old = mtvec_q;
            SEL_SCRATCH: rd_old = mscratch_q;
            SEL_EPC:     rd_old = mepc_q;
            SEL_CAUSE:   rd_old = mcause_q;
            SEL_TVAL:    rd_old = mtval_q;
            SEL_CYC_LO:  rd_old = cyc_val[HALF-1:0];
            SEL_CYC_HI:  rd_old = cyc_val[CNT_W-1:HALF];
            SEL_RET_LO:  rd_old = ret_val[HALF-1:0];
            SEL_RET_HI:  rd_old = ret_val[CNT_W-1:HALF];
            default:     rd_old = '0;
        endcase
    end

    csr_operand_alu u_alu (
        .op      (req_op),
        .imm     (req_imm),
        .rs1_idx (req_rs1_idx),
        .rs1_val (req_rs1_val),
        .old_val (rd_old),
        .skip_wr (skip_wr),
        .new_val (new_val)
    );

    always_comb begin
        ext_exc = exc_ecall | exc_ld_misalign | exc_st_misalign | exc_jmp_misalign;
        illegal = req_valid && (!dec.hit ||
                                (csr_op_e'(req_op) == CSR_OP_RSVD) ||
                                (dec.ro && !skip_wr));
        csr_we  = req_valid && !illegal && !ext_exc && !skip_wr;
    end

    csr_trap_ctrl u_trap (
        .jmp_mis    (exc_jmp_misalign),
        .ld_mis     (exc_ld_misalign),
        .st_mis     (exc_st_misalign),
        .ecall      (exc_ecall),
        .illegal    (illegal),
        .fault_addr (fault_addr),
        .trap       (trap)
    );

    assign ret_inc = retire && !trap.take;

    csr_counter #(.WIDTH(CNT_W)) u_cyc (
        .clk (clk), .rst (rst), .inc (1'b1), .value (cyc_val)
    );

    csr_counter #(.WIDTH(CNT_W)) u_ret (
        .clk (clk), .rst (rst), .inc (ret_inc), .value (ret_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mtvec_q    <= RESET_VEC;
            mepc_q     <= '0;
            mcause_q   <= '0;
            mtval_q    <= '0;
            mscratch_q <= '0;
        end else if (trap.take) begin
            mepc_q   <= insn_pc;
            mcause_q <= trap.cause;
            mtval_q  <= trap.tval;
        end else if (csr_we) begin
            case (dec.sel)
                SEL_TVEC:    mtvec_q    <= new_val;
                SEL_SCRATCH: mscratch_q <= new_val;
                SEL_EPC:     mepc_q     <= new_val;
                SEL_CAUSE:   mcause_q   <= new_val;
                SEL_TVAL:    mtval_q    <= new_val;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid     <= 1'b0;
            resp_rdata     <= '0;
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            resp_valid     <= req_valid && !illegal && !ext_exc;
            resp_rdata     <= rd_old;
            redirect_valid <= trap.take || mret;
            redirect_pc    <= trap.take ? {mtvec_q[XLEN-1:2], 2'b00} : mepc_q;
        end
    end
endmodule

// File: rtl/csr_trap_unit_chk.sv
module csr_trap_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        retire,
    input logic        mret,
    input logic        exc_any,
    input logic        trap_take,
    input logic        resp_valid,
    input logic        redirect_valid,
    input logic [31:0] redirect_pc,
    input logic [31:0] mtvec_q,
    input logic [31:0] mepc_q,
    input logic [63:0] cyc_val,
    input logic [63:0] ret_val
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!resp_valid && !redirect_valid));

    a_r12_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(req_valid));

    a_r8_trap_to_vector: assert property (@(posedge clk) disable iff (rst)
        exc_any |=> (redirect_valid && redirect_pc == ($past(mtvec_q) & 32'hFFFF_FFFC)));

    a_r11_mret_to_epc: assert property (@(posedge clk) disable iff (rst)
        (mret && !exc_any && !req_valid) |=> (redirect_valid && redirect_pc == $past(mepc_q)));

    a_r7_instret_hold: assert property (@(posedge clk) disable iff (rst)
        (!retire || trap_take) |=> (ret_val == $past(ret_val)));

    a_r6_cycle_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cyc_val == $past(cyc_val) + 64'd1));
endmodule

bind csr_trap_unit csr_trap_unit_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .retire         (retire),
    .mret           (mret),
    .exc_any        (ext_exc),
    .trap_take      (trap.take),
    .resp_valid     (resp_valid),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .mtvec_q        (mtvec_q),
    .mepc_q         (mepc_q),
    .cyc_val        (cyc_val),
    .ret_val        (ret_val)
);

// File: tb/csr_trap_unit_bench.sv
module csr_trap_unit_bench;
    localparam logic [31:0] RVEC = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_imm = 0, retire = 0, mret = 0;
    logic [1:0]  req_op = 0;
    logic [11:0] req_addr = 0;
    logic [4:0]  req_rs1_idx = 0;
    logic [31:0] req_rs1_val = 0, insn_pc = 0, fault_addr = 0;
    logic        exc_ecall = 0, exc_ld_misalign = 0, exc_st_misalign = 0, exc_jmp_misalign = 0;
    logic        resp_valid, redirect_valid;
    logic [31:0] resp_rdata, redirect_pc;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_tvec, m_epc, m_cause, m_tval, m_scr;
    logic [63:0] m_cyc, m_ret;

    always #5 clk = ~clk;

    csr_trap_unit #(.RESET_VEC(RVEC)) u_csr_trap_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_imm(req_imm),
        .req_addr(req_addr), .req_rs1_idx(req_rs1_idx), .req_rs1_val(req_rs1_val),
        .insn_pc(insn_pc), .retire(retire), .exc_ecall(exc_ecall),
        .exc_ld_misalign(exc_ld_misalign), .exc_st_misalign(exc_st_misalign),
        .exc_jmp_misalign(exc_jmp_misalign), .fault_addr(fault_addr), .mret(mret),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // 0 = not implemented, 1 = read/write, 2 = read-only counter
    function automatic int kind(input logic [11:0] a);
        case (a)
            12'h305, 12'h340, 12'h341, 12'h342, 12'h343: return 1;
            12'hC00, 12'hC80, 12'hC02, 12'hC82:          return 2;
            default:                                      return 0;
        endcase
    endfunction

    function automatic logic [31:0] mread(input logic [11:0] a);
        case (a)
            12'h305: return m_tvec;
            12'h340: return m_scr;
            12'h341: return m_epc;
            12'h342: return m_cause;
            12'h343: return m_tval;
            12'hC00: return m_cyc[31:0];
            12'hC80: return m_cyc[63:32];
            12'hC02: return m_ret[31:0];
            12'hC82: return m_ret[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic clr_in();
        req_valid = 0; req_op = 0; req_imm = 0; req_addr = 0; req_rs1_idx = 0; req_rs1_val = 0;
        retire = 0; mret = 0; exc_ecall = 0; exc_ld_misalign = 0; exc_st_misalign = 0;
        exc_jmp_misalign = 0; fault_addr = 0; insn_pc = 32'h0000_2000;
    endtask

    // One clock: model predicts from the driven inputs, then outputs are compared.
    task automatic tick(input string tag);
        logic [31:0] opnd, oldv, newv, e_cause, e_tval, e_rd, e_pc;
        logic skip, ill, ext, trap, e_rv, e_redir;
        int k;
        opnd = req_imm ? {27'h0, req_rs1_idx} : req_rs1_val;
        skip = (req_op != 2'b00) && (opnd == 0 || (!req_imm && req_rs1_idx == 0));
        k    = kind(req_addr);
        ill  = req_valid && (k == 0 || req_op == 2'b11 || (k == 2 && !skip));
        ext  = exc_ecall | exc_ld_misalign | exc_st_misalign | exc_jmp_misalign;
        trap = ext || ill;
        e_tval = 0;
        if (exc_jmp_misalign)     begin e_cause = 0;  e_tval = fault_addr; end
        else if (exc_ld_misalign) begin e_cause = 4;  e_tval = fault_addr; end
        else if (exc_st_misalign) begin e_cause = 6;  e_tval = fault_addr; end
        else if (exc_ecall)       e_cause = 11;
        else                      e_cause = 2;
        oldv = mread(req_addr);
        e_rd = oldv;
        e_rv = req_valid && !ill && !ext;
        e_redir = trap || mret;
        e_pc = trap ? {m_tvec[31:2], 2'b00} : m_epc;
        case (req_op)
            2'b01:   newv = oldv | opnd;
            2'b10:   newv = oldv & ~opnd;
            default: newv = opnd;
        endcase
        if (trap) begin
            m_epc = insn_pc; m_cause = e_cause; m_tval = e_tval;
        end else if (req_valid && !skip) begin
            case (req_addr)
                12'h305: m_tvec = newv;
                12'h340: m_scr  = newv;
                12'h341: m_epc  = newv;
                12'h342: m_cause = newv;
                12'h343: m_tval = newv;
                default: ;
            endcase
        end
        m_cyc = m_cyc + 1;
        if (retire && !trap) m_ret = m_ret + 1;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "resp_valid", {31'h0, resp_valid}, {31'h0, e_rv});
        if (e_rv) chk(tag, "resp_rdata", resp_rdata, e_rd);
        chk(tag, "redirect_valid", {31'h0, redirect_valid}, {31'h0, e_redir});
        if (e_redir) chk(tag, "redirect_pc", redirect_pc, e_pc);
        clr_in();
    endtask

    task automatic csr(input logic [1:0] op, input logic imm, input logic [11:0] a,
                       input logic [4:0] rs, input logic [31:0] v, input string tag);
        req_valid = 1; req_op = op; req_imm = imm; req_addr = a; req_rs1_idx = rs; req_rs1_val = v;
        tick(tag);
    endtask

    // read through set with x0: no write, returns current value
    task automatic rd(input logic [11:0] a, input string tag);
        csr(2'b01, 1'b0, a, 5'd0, 32'hFFFF_FFFF, tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        clr_in();
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1", "resp_valid in reset", {31'h0, resp_valid}, 32'h0);
        chk("R1", "redirect_valid in reset", {31'h0, redirect_valid}, 32'h0);
        rst = 0;
        m_tvec = RVEC; m_epc = 0; m_cause = 0; m_tval = 0; m_scr = 0; m_cyc = 0; m_ret = 0;
        tick("R1");                       // idle first cycle
        rd(12'h305, "R1");                // reset vector
        rd(12'h342, "R1");                // cause cleared
        rd(12'hC02, "R1");                // instret zero
        // R2 write returns old
        csr(2'b00, 0, 12'h340, 5'd3, 32'hA5A5_0F0F, "R2");
        rd(12'h340, "R2");
        // R3 set / clear
        csr(2'b01, 0, 12'h340, 5'd4, 32'h0000_F000, "R3");
        csr(2'b10, 0, 12'h340, 5'd4, 32'h0000_0F00, "R3");
        rd(12'h340, "R3");
        // R4 immediate form ignores rs1_val
        csr(2'b00, 1, 12'h340, 5'h1F, 32'hDEAD_BEEF, "R4");
        rd(12'h340, "R4");
        // R5 zero mask / x0: no write, legal on read-only
        csr(2'b01, 1, 12'h340, 5'd0, 32'hFFFF_FFFF, "R5");
        csr(2'b10, 0, 12'h340, 5'd7, 32'h0, "R5");
        rd(12'h340, "R5");
        csr(2'b10, 1, 12'hC00, 5'd0, 32'h0, "R5");
        // R6 cycle counter halves
        rd(12'hC00, "R6");
        rd(12'hC80, "R6");
        // R7 retire counting, trap blocks it
        repeat (3) begin retire = 1; tick("R7"); end
        retire = 1; exc_ecall = 1; insn_pc = 32'h0000_3000; tick("R7");
        rd(12'hC02, "R7");
        rd(12'hC82, "R7");
        // R8 ecall trap state
        rd(12'h341, "R8"); rd(12'h342, "R8"); rd(12'h343, "R8");
        exc_ld_misalign = 1; fault_addr = 32'h0000_1003; insn_pc = 32'h0000_3010; tick("R8");
        rd(12'h343, "R8"); rd(12'h342, "R8");
        csr(2'b00, 0, 12'h305, 5'd1, 32'h0000_4003, "R8");
        exc_ecall = 1; tick("R8");
        // R9 priority and dropped request
        exc_st_misalign = 1; exc_jmp_misalign = 1; fault_addr = 32'h0000_0102; tick("R9");
        rd(12'h342, "R9");
        exc_st_misalign = 1; exc_ecall = 1; fault_addr = 32'h0000_0055; tick("R9");
        rd(12'h342, "R9");
        exc_ecall = 1; req_valid = 1; req_op = 2'b00; req_addr = 12'h340; req_rs1_idx = 5'd2;
        req_rs1_val = 32'h1234_5678; tick("R9");
        rd(12'h340, "R9");
        // R10 illegal accesses
        csr(2'b01, 0, 12'h7C0, 5'd0, 32'h0, "R10"); rd(12'h342, "R10");
        csr(2'b00, 0, 12'hC00, 5'd1, 32'h5, "R10"); rd(12'h342, "R10");
        csr(2'b11, 0, 12'h340, 5'd1, 32'h5, "R10"); rd(12'h342, "R10");
        // R11 return
        csr(2'b00, 0, 12'h341, 5'd1, 32'h0000_8888, "R11");
        mret = 1; tick("R11");
        mret = 1; exc_ecall = 1; tick("R11");
        // random mix (R2 R3 R12)
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 55) begin
                logic [11:0] al [10] = '{12'h305, 12'h340, 12'h341, 12'h342, 12'h343,
                                         12'hC00, 12'hC80, 12'hC02, 12'hC82, 12'h3A0};
                req_valid = 1;
                req_op = ($urandom_range(0, 9) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
                req_imm = 1'($urandom_range(0, 1));
                req_addr = al[$urandom_range(0, 9)];
                req_rs1_idx = 5'($urandom_range(0, 31));
                req_rs1_val = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
            end
            retire = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 9) == 0) exc_ecall = 1;
            if ($urandom_range(0, 14) == 0) exc_ld_misalign = 1;
            if ($urandom_range(0, 14) == 0) exc_st_misalign = 1;
            if ($urandom_range(0, 19) == 0) exc_jmp_misalign = 1;
            if ($urandom_range(0, 11) == 0 && !req_valid) mret = 1;
            fault_addr = $urandom;
            insn_pc = $urandom;
            tick("R12");
        end
        rd(12'hC02, "R7");
        rd(12'hC00, "R6");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule